// File: doc/BRIEF.md
# Converter Test Pattern Generator

This block forms the transmit sample word that feeds a multi-lane, multi-converter data link. Each word carries one sample per converter per link. Every sample is `SBITS` wide, and the frame clock moves one sample per converter on each cycle. A 4-bit mode input chooses the source of the word. In the user mode, samples from a valid/ready stream pass straight through. Three built-in generators cover bring-up and link testing: a checkerboard, a ramp and a pseudo-random sequence. The remaining mode codes silence the output.

The downstream consumer paces the generators through its ready signal. A test pattern moves forward one frame only when a frame is accepted. When a generator is not selected, it is held at its starting value. As a result, every entry into a test mode begins the sequence from its start.

Top module: `conv_pattern_gen`

## Requirements
- R1: In mode 4'b0000, out_data equals usr_data, out_valid equals usr_valid and usr_ready equals out_ready, all in the same cycle.
- R2: For any mode other than 4'b0000, usr_ready is 0.
- R3: In mode 4'b1000, sample k is 0xAA-style (bit i set exactly when i is odd) when (phase XOR k[0]) is 0, and 0x55-style otherwise. The phase starts at 0 and toggles on each accepted frame.
- R4: In mode 4'b1001, sample k equals (count + k) mod 2^SBITS. The count starts at 0, rises by 1 on each accepted frame and wraps to 0 after 2^SBITS-1.
- R5: In mode 4'b1010, sample k comes from its own 7-bit register with feedback x^7+x^6+1. The register starts at ((k mod 127)+1). Each step computes b = r[6]^r[5] and then sets r = {r[5:0], b}. The j-th bit produced (j = 0..SBITS-1) goes to sample bit SBITS-1-j. An accepted frame leaves the register SBITS steps further on.
- R6: Sample k = link*CONVS + conv occupies out_data[k*SBITS +: SBITS], lowest index in the lowest bits.
- R7: In a test mode, a cycle with out_ready low leaves the pattern unchanged for the next cycle.
- R8: For every code other than 0000, 1000, 1001 and 1010, out_data is all zeros and out_valid is 0.
- R9: A test pattern shows its starting value in the first cycle after its mode is entered from any other mode, reserved codes included.
- R10: In the three test modes, out_valid is 1 in every cycle, whatever the state of out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Source select code |
| usr_data | input | LINKS*CONVS*SBITS | User sample word |
| usr_valid | input | 1 | User word valid |
| usr_ready | output | 1 | Block accepts the user word |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | LINKS*CONVS*SBITS | Packed output sample word |
| out_valid | output | 1 | Output word valid |

## Verification
The bench builds the block with two links, two converters and 8-bit samples. This setting makes the ramp wrap after 256 accepted frames, so a single run can reach it. With four samples per word, the packing order can be observed: both checkerboard phases appear side by side, and four distinct PRBS seeds run in parallel. Mode switches through other patterns and through reserved codes test that each generator restarts. Stalled cycles show that a pattern holds its value.

// File: rtl/conv_pg_pkg.sv
package conv_pg_pkg;

    typedef enum logic [3:0] {
        PG_MODE_USER  = 4'b0000,
        PG_MODE_CHECK = 4'b1000,
        PG_MODE_RAMP  = 4'b1001,
        PG_MODE_PRBS  = 4'b1010
    } pg_mode_e;

    typedef struct packed {
        logic user;
        logic check;
        logic ramp;
        logic prbs;
    } pg_sel_t;

    localparam int PG_LFSR_W = 7;

endpackage

// File: rtl/pg_mode_decode.sv
module pg_mode_decode
    import conv_pg_pkg::*;
(
    input  logic [3:0] mode,
    output pg_sel_t    sel
);

    always_comb begin
        sel = '0;
        case (mode)
            PG_MODE_USER:  sel.user  = 1'b1;
            PG_MODE_CHECK: sel.check = 1'b1;
            PG_MODE_RAMP:  sel.ramp  = 1'b1;
            PG_MODE_PRBS:  sel.prbs  = 1'b1;
            default:       sel       = '0;
        endcase
    end

endmodule

// File: rtl/pg_checker_src.sv
module pg_checker_src #(
    parameter int SAMPLES = 4,
    parameter int SBITS   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active,
    input  logic                       adv,
    output logic [SAMPLES*SBITS-1:0]   word
);

    function automatic logic [SBITS-1:0] alt_bits();
        logic [SBITS-1:0] r;
        for (int i = 0; i < SBITS; i++) begin
            r[i] = (i % 2 == 1);
        end
        return r;
    endfunction

    localparam logic [SBITS-1:0] PAT_HI = alt_bits();

    typedef struct packed {
        logic phase;
    } chk_state_t;

    chk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d.phase = 1'b0;
        end else if (adv) begin
            st_d.phase = ~st_q.phase;
        end
        for (int k = 0; k < SAMPLES; k++) begin
            word[k*SBITS +: SBITS] = (st_q.phase ^ (k % 2 == 1)) ? ~PAT_HI : PAT_HI;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_phase_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && adv) |=> (st_q.phase != $past(st_q.phase)));

    assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !adv) |=> $stable(st_q.phase));

    assert_phase_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st_q.phase == 1'b0));

endmodule

// File: rtl/pg_ramp_src.sv
module pg_ramp_src #(
    parameter int SAMPLES = 4,
    parameter int SBITS   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active,
    input  logic                       adv,
    output logic [SAMPLES*SBITS-1:0]   word
);

    typedef struct packed {
        logic [SBITS-1:0] cnt;
    } ramp_state_t;

    ramp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d.cnt = '0;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        for (int k = 0; k < SAMPLES; k++) begin
            word[k*SBITS +: SBITS] = st_q.cnt + SBITS'(k);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_ramp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && adv) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    assert_ramp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !adv) |=> $stable(st_q.cnt));

    assert_ramp_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st_q.cnt == '0));

endmodule

// File: rtl/pg_prbs_lane.sv
module pg_prbs_lane
    import conv_pg_pkg::*;
#(
    parameter int SBITS = 16,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             adv,
    output logic [SBITS-1:0] smp
);

    localparam logic [PG_LFSR_W-1:0] SEED = PG_LFSR_W'((IDX % 127) + 1);

    typedef struct packed {
        logic [PG_LFSR_W-1:0] lfsr;
    } lane_state_t;

    lane_state_t          st_d, st_q;
    logic [PG_LFSR_W-1:0] walk;
    logic                 fb;

    always_comb begin
        walk = st_q.lfsr;
        fb   = 1'b0;
        smp  = '0;
        for (int j = 0; j < SBITS; j++) begin
            fb   = walk[6] ^ walk[5];
            walk = {walk[5:0], fb};
            smp[SBITS-1-j] = fb;
        end
        st_d = st_q;
        if (!active) begin
            st_d.lfsr = SEED;
        end else if (adv) begin
            st_d.lfsr = walk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lfsr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assert_lfsr_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lfsr != '0);

    assert_lfsr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !adv) |=> $stable(st_q.lfsr));

    assert_lfsr_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st_q.lfsr == SEED));

endmodule

// File: rtl/conv_pattern_gen.sv
module conv_pattern_gen
    import conv_pg_pkg::*;
#(
    parameter int LINKS = 2,
    parameter int CONVS = 2,
    parameter int SBITS = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [3:0]                       mode,
    input  logic [LINKS*CONVS*SBITS-1:0]     usr_data,
    input  logic                             usr_valid,
    output logic                             usr_ready,
    input  logic                             out_ready,
    output logic [LINKS*CONVS*SBITS-1:0]     out_data,
    output logic                             out_valid
);

    localparam int SAMPLES = LINKS * CONVS;
    localparam int WORD_W  = SAMPLES * SBITS;

    pg_sel_t            sel;
    logic [WORD_W-1:0]  chk_word;
    logic [WORD_W-1:0]  ramp_word;
    logic [WORD_W-1:0]  prbs_word;

    pg_mode_decode i_decode (
        .mode (mode),
        .sel  (sel)
    );

    pg_checker_src #(.SAMPLES(SAMPLES), .SBITS(SBITS)) i_check (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (sel.check),
        .adv    (out_ready),
        .word   (chk_word)
    );

    pg_ramp_src #(.SAMPLES(SAMPLES), .SBITS(SBITS)) i_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (sel.ramp),
        .adv    (out_ready),
        .word   (ramp_word)
    );

    for (genvar g = 0; g < SAMPLES; g++) begin : g_lane
        pg_prbs_lane #(.SBITS(SBITS), .IDX(g)) i_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (sel.prbs),
            .adv    (out_ready),
            .smp    (prbs_word[g*SBITS +: SBITS])
        );
    end

    always_comb begin
        out_data  = '0;
        out_valid = 1'b0;
        usr_ready = 1'b0;
        unique0 case (1'b1)
            sel.user: begin
                out_data  = usr_data;
                out_valid = usr_valid;
                usr_ready = out_ready;
            end
            sel.check: begin
                out_data  = chk_word;
                out_valid = 1'b1;
            end
            sel.ramp: begin
                out_data  = ramp_word;
                out_valid = 1'b1;
            end
            sel.prbs: begin
                out_data  = prbs_word;
                out_valid = 1'b1;
            end
        endcase
    end

    assert_user_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 4'b0000) |-> !usr_ready);

    assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 4'b0000 && mode != 4'b1000 && mode != 4'b1001 && mode != 4'b1010)
        |-> (!out_valid && out_data == '0));

    assert_test_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'b1000 || mode == 4'b1001 || mode == 4'b1010) |-> out_valid);

    assert_single_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

endmodule

// File: tb/test_conv_pattern_gen.sv
module test_conv_pattern_gen;

    localparam int LK = 2;
    localparam int CV = 2;
    localparam int NB = 8;
    localparam int NS = LK * CV;
    localparam int W  = NS * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    mode = 4'b0000;
    logic [W-1:0]  usr_data = '0;
    logic          usr_valid = 1'b0;
    logic          usr_ready;
    logic          out_ready = 1'b0;
    logic [W-1:0]  out_data;
    logic          out_valid;

    always #2 clk = ~clk;

    conv_pattern_gen #(.LINKS(LK), .CONVS(CV), .SBITS(NB)) i_conv_pattern_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .usr_data  (usr_data),
        .usr_valid (usr_valid),
        .usr_ready (usr_ready),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    typedef struct {
        logic [W-1:0] data;
        logic         valid;
        logic         ready;
        string        dtag;
        string        vtag;
        string        rtag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // model state
    logic       m_phase = 1'b0;
    logic [7:0] m_cnt   = '0;
    logic [6:0] m_lfsr [NS];
    logic [3:0] m_prev  = 4'b0000;

    function automatic logic is_test(input logic [3:0] md);
        return (md == 4'b1000) || (md == 4'b1001) || (md == 4'b1010);
    endfunction

    function automatic logic [NB-1:0] prbs_bits(input logic [6:0] r0, output logic [6:0] r_out);
        logic [6:0]    r = r0;
        logic [NB-1:0] s = '0;
        for (int j = 0; j < NB; j++) begin
            logic b;
            b = r[6] ^ r[5];
            r = {r[5:0], b};
            s[NB-1-j] = b;
        end
        r_out = r;
        return s;
    endfunction

    task automatic step(input logic [3:0] md, input logic rdy, input logic uv, input logic [W-1:0] ud);
        exp_t e;
        logic [6:0] nxt [NS];
        @(negedge clk);
        mode      = md;
        out_ready = rdy;
        usr_valid = uv;
        usr_data  = ud;
        e.data  = '0;
        e.valid = 1'b0;
        e.ready = 1'b0;
        for (int l = 0; l < LK; l++) begin
            for (int c = 0; c < CV; c++) begin
                int k;
                logic [NB-1:0] s;
                k = l * CV + c;
                s = prbs_bits(m_lfsr[k], nxt[k]);
                case (md)
                    4'b1000: e.data[k*NB +: NB] = (m_phase ^ (k % 2 == 1)) ? 8'h55 : 8'hAA;
                    4'b1001: e.data[k*NB +: NB] = m_cnt + 8'(k);
                    4'b1010: e.data[k*NB +: NB] = s;
                    default: ;
                endcase
            end
        end
        if (md == 4'b0000) begin
            e.data  = ud;
            e.valid = uv;
            e.ready = rdy;
            e.dtag  = "R1";
        end else if (is_test(md)) begin
            e.valid = 1'b1;
            if (md != m_prev)      e.dtag = "R9";
            else if (!rdy)         e.dtag = "R7";
            else if (md == 4'b1000) e.dtag = "R3";
            else if (md == 4'b1001) e.dtag = "R4 R6";
            else                   e.dtag = "R5 R6";
        end else begin
            e.dtag = "R8";
        end
        e.vtag = is_test(md) ? "R10" : e.dtag;
        e.rtag = (md == 4'b0000) ? "R1" : "R2";
        q.push_back(e);
        // advance model to the state after this clock edge
        if (md == 4'b1000) begin
            if (rdy) m_phase = ~m_phase;
        end else begin
            m_phase = 1'b0;
        end
        if (md == 4'b1001) begin
            if (rdy) m_cnt = m_cnt + 8'd1;
        end else begin
            m_cnt = '0;
        end
        for (int k = 0; k < NS; k++) begin
            if (md == 4'b1010) begin
                if (rdy) m_lfsr[k] = nxt[k];
            end else begin
                m_lfsr[k] = 7'((k % 127) + 1);
            end
        end
        m_prev = md;
    endtask

    // monitor: compares outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (out_data !== e.data) begin
                    fails++;
                    $display("FAIL %s out_data: got %h exp %h", e.dtag, out_data, e.data);
                end
                checks++;
                if (out_valid !== e.valid) begin
                    fails++;
                    $display("FAIL %s out_valid: got %b exp %b", e.vtag, out_valid, e.valid);
                end
                checks++;
                if (usr_ready !== e.ready) begin
                    fails++;
                    $display("FAIL %s usr_ready: got %b exp %b", e.rtag, usr_ready, e.ready);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NS; k++) m_lfsr[k] = 7'((k % 127) + 1);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state, pass-through (R1)
        step(4'b0000, 1'b0, 1'b0, 32'h0000_0000);
        step(4'b0000, 1'b1, 1'b1, 32'h1122_3344);
        step(4'b0000, 1'b0, 1'b1, 32'hA5A5_5A5A);
        step(4'b0000, 1'b1, 1'b0, 32'hDEAD_BEEF);

        // checkerboard with stalls (R3, R7, R2, R10)
        step(4'b1000, 1'b1, 1'b1, 32'hFFFF_FFFF);
        step(4'b1000, 1'b1, 1'b1, 32'hFFFF_FFFF);
        step(4'b1000, 1'b0, 1'b0, 32'h0);
        step(4'b1000, 1'b1, 1'b0, 32'h0);
        step(4'b1000, 1'b0, 1'b1, 32'h1234_5678);
        step(4'b1000, 1'b1, 1'b0, 32'h0);

        // ramp with stalls, restart on re-entry (R4, R7, R9)
        step(4'b1001, 1'b1, 1'b0, 32'h0);
        step(4'b1001, 1'b0, 1'b0, 32'h0);
        step(4'b1001, 1'b1, 1'b0, 32'h0);
        step(4'b1001, 1'b1, 1'b0, 32'h0);
        step(4'b1000, 1'b1, 1'b0, 32'h0);
        for (int i = 0; i < 3; i++) step(4'b1001, 1'b1, 1'b0, 32'h0);
        // wrap at 2^8 (R4)
        for (int i = 0; i < 260; i++) step(4'b1001, 1'b1, 1'b0, 32'h0);

        // PRBS with stalls and restart (R5, R7, R9)
        for (int i = 0; i < 20; i++) step(4'b1010, (i % 3 != 0), 1'b0, 32'h0);
        step(4'b1001, 1'b1, 1'b0, 32'h0);
        for (int i = 0; i < 3; i++) step(4'b1010, 1'b1, 1'b0, 32'h0);

        // reserved codes (R8, R2)
        step(4'b0001, 1'b1, 1'b1, 32'hCAFE_F00D);
        step(4'b0111, 1'b1, 1'b1, 32'hCAFE_F00D);
        step(4'b1011, 1'b1, 1'b1, 32'hCAFE_F00D);
        step(4'b1111, 1'b1, 1'b1, 32'hCAFE_F00D);
        step(4'b0100, 1'b0, 1'b1, 32'hCAFE_F00D);

        // re-entry after reserved (R9)
        step(4'b1010, 1'b1, 1'b0, 32'h0);
        step(4'b1010, 1'b1, 1'b0, 32'h0);
        step(4'b1000, 1'b0, 1'b0, 32'h0);
        step(4'b1000, 1'b1, 1'b0, 32'h0);
        step(4'b0000, 1'b1, 1'b1, 32'h0BAD_C0DE);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule